// File: doc/BRIEF.md
# Grouped External Interrupt Controller

This block watches 28 external interrupt lines, numbered 0 to 27. Each line is first brought into the clock domain by a two-stage synchroniser. Its event is then detected under a trigger mode that is programmed per pair of adjacent lines. Detected events are held in a per-line pending flag. A per-line mask decides whether that flag reaches one of four combined interrupt outputs. The four outputs cover unequal line groups of 4, 8, 8 and 8 lines, and each one feeds one input of a parent interrupt controller.

Software uses a small word-wide register bus with four locations. Two locations hold the packed trigger fields, one holds the mask and one holds the pending flags. A pending flag is cleared by writing 1 to it. The handler reads the pending register, ANDs it with the inverted mask to find the lines to service, and clears the lines it has handled.

Top module: `eint_grp_ctrl`

## Requirements
- R1: After reset, the low trigger register reads 0x11111111, the high trigger register reads 0x00111111 (every field high level), the mask register reads 0x0FFFFFFF (all lines masked), the pending register reads 0, and grp_irq is 0.
- R2: Bus address 0 is the low trigger register, 1 is the high trigger register, 2 is the mask and 3 is the pending register. A write takes effect on the clock edge that samples bus_we. bus_rdata shows the addressed register combinationally. In the trigger registers only bits 4k to 4k+2 are stored; all other bits read 0.
- R3: Line n below 16 uses the 3-bit field at bit (n/2)*4 of the low trigger register. Line n from 16 to 27 uses the field at bit ((n-16)/2)*4 of the high trigger register, so the field for lines 26 and 27 sits at bits 20 to 22.
- R4: Field value 000 is low level and 001 is high level. In a level mode the pending flag is set on every cycle the synchronised input is at its active level, so a clear written while the level is active has no lasting effect.
- R5: Field 010 or 011 is falling edge, 100 or 101 is rising edge, and 110 or 111 is both edges. Edges are found by comparing the synchronised sample with the one before it. The pending flag becomes visible after the third rising clock edge that follows an input change.
- R6: Writing 1 to a pending bit clears that flag. Writing 0 leaves it unchanged.
- R7: When an event and a write-1 clear reach the same line in the same cycle, the flag stays set.
- R8: Mask bit n set masks line n. A masked line's pending flag still reads back in the pending register, and masking only gates the group outputs.
- R9: grp_irq[0] is the OR of the unmasked pending flags of lines 0-3. grp_irq[1] covers lines 4-11, grp_irq[2] covers lines 12-19 and grp_irq[3] covers lines 20-27.
- R10: Bits 28 to 31 name no line. Writing them in the mask or pending register has no effect, and they read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 28 | External interrupt lines, asynchronous to clk |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register |
| grp_irq | output | 4 | Combined interrupt per line group |

## Verification
Random trials pick a line, a trigger code and an old and new input level. Across these trials each of the eight codes is tried with steady levels, rising steps and falling steps, which tells level sensitivity apart from each edge polarity. Directed cases pulse the first and last line of every group to expose a wrong group boundary. They program a falling trigger on line 27 and then raise the line, which exposes a field read from the wrong position. They also issue a clear in the exact cycle an edge is detected, which separates event priority from clear priority. Writes to bits 28 to 31 and clears written while a level is held show which writes really take effect.

// File: rtl/eint_pkg.sv
package eint_pkg;
  localparam int NLINES       = 28;
  localparam int LO_LINES     = 16;
  localparam int DATA_W       = 32;
  localparam int ADDR_W       = 2;
  localparam int FIELD_W      = 3;
  localparam int FIELD_STRIDE = 4;
  localparam int NGROUPS      = 4;
  localparam int GRP0_SIZE    = 4;
  localparam int GRP_SIZE     = 8;
  localparam int LO_FIELDS    = LO_LINES / 2;
  localparam int HI_FIELDS    = (NLINES - LO_LINES) / 2;

  typedef enum logic [1:0] {
    TRIG_LEVEL = 2'b00,
    TRIG_FALL  = 2'b01,
    TRIG_RISE  = 2'b10,
    TRIG_BOTH  = 2'b11
  } trig_kind_e;

  typedef enum logic [ADDR_W-1:0] {
    REG_CFG_LO = 2'd0,
    REG_CFG_HI = 2'd1,
    REG_MASK   = 2'd2,
    REG_PEND   = 2'd3
  } reg_addr_e;

  function automatic int field_lsb(int n);
    if (n < LO_LINES) return (n / 2) * FIELD_STRIDE;
    return ((n - LO_LINES) / 2) * FIELD_STRIDE;
  endfunction

  function automatic logic [DATA_W-1:0] cfg_keep(int nfields);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int k = 0; k < nfields; k++) m[k*FIELD_STRIDE +: FIELD_W] = '1;
    return m;
  endfunction

  function automatic logic [DATA_W-1:0] cfg_reset(int nfields);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int k = 0; k < nfields; k++) m[k*FIELD_STRIDE] = 1'b1;
    return m;
  endfunction

  function automatic int grp_first(int g);
    if (g == 0) return 0;
    return GRP0_SIZE + (g - 1) * GRP_SIZE;
  endfunction

  function automatic int grp_last(int g);
    if (g == 0) return GRP0_SIZE - 1;
    return GRP0_SIZE + g * GRP_SIZE - 1;
  endfunction
endpackage

// File: rtl/eint_sync.sv
module eint_sync #(
  parameter int W      = 28,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stage_q [STAGES];
  logic [W-1:0] stage_d [STAGES];

  always_comb begin
    stage_d[0] = async_in;
    for (int s = 1; s < STAGES; s++) stage_d[s] = stage_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= stage_d[s];
    end
  end

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/eint_detect.sv
module eint_detect
  import eint_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] smp,
  input  logic [DATA_W-1:0] cfg_lo,
  input  logic [DATA_W-1:0] cfg_hi,
  output logic [NLINES-1:0] evt
);
  localparam logic [DATA_W-1:0] KEEP_LO = cfg_keep(LO_FIELDS);
  localparam logic [DATA_W-1:0] KEEP_HI = cfg_keep(HI_FIELDS);

  logic [NLINES-1:0] prev_q;
  logic [NLINES-1:0] prev_d;
  logic              unused_cfg;

  assign unused_cfg = ^{cfg_lo & ~KEEP_LO, cfg_hi & ~KEEP_HI};

  always_comb prev_d = smp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    localparam int LSB = field_lsb(i);
    logic [FIELD_W-1:0] fld;
    if (i < LO_LINES) begin : g_lo
      assign fld = cfg_lo[LSB +: FIELD_W];
    end else begin : g_hi
      assign fld = cfg_hi[LSB +: FIELD_W];
    end

    always_comb begin
      unique case (trig_kind_e'(fld[2:1]))
        TRIG_LEVEL: evt[i] = (smp[i] == fld[0]);
        TRIG_FALL:  evt[i] = prev_q[i] & ~smp[i];
        TRIG_RISE:  evt[i] = ~prev_q[i] & smp[i];
        TRIG_BOTH:  evt[i] = prev_q[i] ^ smp[i];
        default:    evt[i] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/eint_regs.sv
module eint_regs
  import eint_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NLINES-1:0] evt,
  output logic [DATA_W-1:0] cfg_lo_q,
  output logic [DATA_W-1:0] cfg_hi_q,
  output logic [NLINES-1:0] mask_q,
  output logic [NLINES-1:0] pend_q
);
  localparam logic [DATA_W-1:0] KEEP_LO = cfg_keep(LO_FIELDS);
  localparam logic [DATA_W-1:0] KEEP_HI = cfg_keep(HI_FIELDS);
  localparam logic [DATA_W-1:0] RST_LO  = cfg_reset(LO_FIELDS);
  localparam logic [DATA_W-1:0] RST_HI  = cfg_reset(HI_FIELDS);
  localparam int                PAD     = DATA_W - NLINES;

  logic [DATA_W-1:0] cfg_lo_d, cfg_hi_d;
  logic [NLINES-1:0] mask_d, pend_d, clr;
  logic              wr_lo, wr_hi, wr_mask, wr_pend;

  always_comb begin
    wr_lo   = bus_we && (reg_addr_e'(bus_addr) == REG_CFG_LO);
    wr_hi   = bus_we && (reg_addr_e'(bus_addr) == REG_CFG_HI);
    wr_mask = bus_we && (reg_addr_e'(bus_addr) == REG_MASK);
    wr_pend = bus_we && (reg_addr_e'(bus_addr) == REG_PEND);
    clr     = wr_pend ? bus_wdata[NLINES-1:0] : '0;

    cfg_lo_d = wr_lo   ? (bus_wdata & KEEP_LO) : cfg_lo_q;
    cfg_hi_d = wr_hi   ? (bus_wdata & KEEP_HI) : cfg_hi_q;
    mask_d   = wr_mask ? bus_wdata[NLINES-1:0] : mask_q;
    pend_d   = (pend_q & ~clr) | evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_lo_q <= RST_LO;
      cfg_hi_q <= RST_HI;
      mask_q   <= '1;
      pend_q   <= '0;
    end else begin
      cfg_lo_q <= cfg_lo_d;
      cfg_hi_q <= cfg_hi_d;
      mask_q   <= mask_d;
      pend_q   <= pend_d;
    end
  end

  always_comb begin
    unique case (reg_addr_e'(bus_addr))
      REG_CFG_LO: bus_rdata = cfg_lo_q;
      REG_CFG_HI: bus_rdata = cfg_hi_q;
      REG_MASK:   bus_rdata = {{PAD{1'b0}}, mask_q};
      REG_PEND:   bus_rdata = {{PAD{1'b0}}, pend_q};
      default:    bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/eint_group.sv
module eint_group
  import eint_pkg::*;
(
  input  logic [NLINES-1:0]  pend,
  input  logic [NLINES-1:0]  mask,
  output logic [NGROUPS-1:0] grp
);
  logic [NLINES-1:0] live;
  assign live = pend & ~mask;

  for (genvar g = 0; g < NGROUPS; g++) begin : g_grp
    localparam int FIRST = grp_first(g);
    localparam int LAST  = grp_last(g);
    assign grp[g] = |live[LAST:FIRST];
  end
endmodule

// File: rtl/eint_grp_ctrl.sv
module eint_grp_ctrl
  import eint_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [27:0]         line_in,
  input  logic                bus_we,
  input  logic [1:0]          bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  output logic [3:0]          grp_irq
);
  logic [NLINES-1:0] line_smp;
  logic [NLINES-1:0] line_evt;
  logic [NLINES-1:0] mask_q;
  logic [NLINES-1:0] pend_q;
  logic [DATA_W-1:0] cfg_lo_q;
  logic [DATA_W-1:0] cfg_hi_q;

  eint_sync #(.W(NLINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(line_in), .sync_out(line_smp)
  );

  eint_detect u_det (
    .clk(clk), .rst_n(rst_n), .smp(line_smp),
    .cfg_lo(cfg_lo_q), .cfg_hi(cfg_hi_q), .evt(line_evt)
  );

  eint_regs u_regs (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt(line_evt),
    .cfg_lo_q(cfg_lo_q), .cfg_hi_q(cfg_hi_q), .mask_q(mask_q), .pend_q(pend_q)
  );

  eint_group u_grp (
    .pend(pend_q), .mask(mask_q), .grp(grp_irq)
  );
endmodule

// File: rtl/eint_grp_ctrl_chk.sv
module eint_grp_ctrl_chk
  import eint_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [NLINES-1:0] wdata_lines,
  input logic [NLINES-1:0] pend_q,
  input logic [NLINES-1:0] mask_q,
  input logic [NLINES-1:0] evt,
  input logic [NGROUPS-1:0] grp_irq
);
  logic pend_wr, mask_wr;
  assign pend_wr = bus_we && (bus_addr == 2'd3);
  assign mask_wr = bus_we && (bus_addr == 2'd2);

  // R6: a cleared flag with no event in that cycle is gone next cycle
  a_r6_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    pend_wr |=> ((pend_q & $past(wdata_lines) & ~$past(evt)) == '0));

  // R6: with no clear and no event the flags hold
  a_r6_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_wr && (evt == '0)) |=> (pend_q == $past(pend_q)));

  // R7: an event always leaves its flag set, clear or not
  a_r7_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((pend_q & $past(evt)) == $past(evt)));

  // R8: the mask changes only through a mask write
  a_r8_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_wr |=> $stable(mask_q));

  // R8: a fully masked controller keeps every group output low
  a_r8_all_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '1) |-> (grp_irq == '0));

  // R9: a group output needs some unmasked pending flag behind it
  a_r9_grp_has_source: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_irq != '0) |-> ((pend_q & ~mask_q) != '0));
endmodule

bind eint_grp_ctrl eint_grp_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .wdata_lines(bus_wdata[27:0]), .pend_q(pend_q), .mask_q(mask_q),
  .evt(line_evt), .grp_irq(grp_irq)
);

// File: tb/eint_grp_ctrl_test.sv
module eint_grp_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] RST_LO = 32'h1111_1111;
  localparam logic [31:0] RST_HI = 32'h0011_1111;

  logic        clk;
  logic        rst_n;
  logic [27:0] line_in;
  logic        bus_we;
  logic [1:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [3:0]  grp_irq;

  int n_checks;
  int n_fail;
  int cycles;
  bit done;

  eint_grp_ctrl uut (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .grp_irq(grp_irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
        summary();
      end
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  function automatic int lsb_of(int n);
    if (n < 16) return (n / 2) * 4;
    return ((n - 16) / 2) * 4;
  endfunction

  function automatic logic [3:0] grp_of(int n);
    if (n < 4)  return 4'b0001;
    if (n < 12) return 4'b0010;
    if (n < 20) return 4'b0100;
    return 4'b1000;
  endfunction

  function automatic bit lvl_act(logic [2:0] m, bit v);
    return (m[2:1] == 2'b00) && (v == m[0]);
  endfunction

  function automatic bit exp_flag(logic [2:0] m, bit v0, bit v1);
    case (m[2:1])
      2'b00:   return lvl_act(m, v0) || lvl_act(m, v1);
      2'b01:   return v0 && !v1;
      2'b10:   return !v0 && v1;
      default: return v0 != v1;
    endcase
  endfunction

  task automatic restore();
    line_in = '0;
    step(4);
    wr(2'd0, RST_LO);
    wr(2'd1, RST_HI);
    step(1);
    wr(2'd3, 32'hFFFF_FFFF);
    step(1);
  endtask

  task automatic pulse_high(int n);
    line_in[n] = 1'b1;
    step(3);
    line_in[n] = 1'b0;
    step(3);
  endtask

  initial begin
    logic [31:0] rv;
    int seed_dummy;
    done = 1'b0;
    n_checks = 0;
    n_fail = 0;
    rst_n = 1'b0;
    line_in = '0;
    bus_we = 1'b0;
    bus_addr = '0;
    bus_wdata = '0;
    seed_dummy = $urandom(32'd4711);
    step(3);
    rst_n = 1'b1;
    step(1);

    // R1 reset state
    rd(2'd0, rv); check("R1 cfg lo reset", rv, RST_LO);
    rd(2'd1, rv); check("R1 cfg hi reset", rv, RST_HI);
    rd(2'd2, rv); check("R1 mask reset", rv, 32'h0FFF_FFFF);
    rd(2'd3, rv); check("R1 pend reset", rv, 32'h0);
    check("R1 grp reset", {28'h0, grp_irq}, 32'h0);

    // R2 stored field bits only
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, rv); check("R2 cfg lo field bits", rv, 32'h7777_7777);
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, rv); check("R2 cfg hi field bits", rv, 32'h0077_7777);
    restore();

    // R10 unused mask bits
    wr(2'd2, 32'hF000_0000);
    rd(2'd2, rv); check("R10 mask upper bits ignored", rv, 32'h0);
    wr(2'd2, 32'hFFFF_FFFF);
    rd(2'd2, rv); check("R10 mask upper bits read 0", rv, 32'h0FFF_FFFF);

    // R3 field of lines 26/27 at bits 20..22: falling edge
    wr(2'd1, (RST_HI & ~(32'h7 << 20)) | (32'h2 << 20));
    step(1);
    wr(2'd3, 32'hFFFF_FFFF);
    line_in[27] = 1'b1;
    step(4);
    rd(2'd3, rv); check("R3 line27 rise ignored in falling mode", rv & (1 << 27), 32'h0);
    line_in[27] = 1'b0;
    step(3);
    rd(2'd3, rv); check("R3 line27 falling edge pends", rv & (1 << 27), 32'h1 << 27);
    restore();

    // R4 high level holds against clears
    line_in[5] = 1'b1;
    step(3);
    rd(2'd3, rv); check("R4 high level pends", rv & (1 << 5), 32'h1 << 5);
    wr(2'd3, 32'h1 << 5);
    rd(2'd3, rv); check("R4 clear while level active", rv & (1 << 5), 32'h1 << 5);
    line_in[5] = 1'b0;
    step(3);
    wr(2'd3, 32'h1 << 5);
    rd(2'd3, rv); check("R4 clear after level gone", rv & (1 << 5), 32'h0);

    // R6 write 0 keeps, write 1 clears
    pulse_high(9);
    wr(2'd3, 32'h0);
    rd(2'd3, rv); check("R6 write 0 keeps flag", rv, 32'h1 << 9);
    wr(2'd3, 32'hF000_0000);
    rd(2'd3, rv); check("R10 pend upper bits ignored", rv, 32'h1 << 9);
    wr(2'd3, 32'h1 << 9);
    rd(2'd3, rv); check("R6 write 1 clears flag", rv, 32'h0);

    // R7 clear in the cycle the edge is detected
    wr(2'd0, (RST_LO & ~(32'h7 << 16)) | (32'h4 << 16));
    step(1);
    wr(2'd3, 32'hFFFF_FFFF);
    line_in[8] = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    wr(2'd3, 32'h1 << 8);
    rd(2'd3, rv); check("R7 event beats same-cycle clear", rv & (1 << 8), 32'h1 << 8);
    wr(2'd3, 32'h1 << 8);
    rd(2'd3, rv); check("R7 later clear works", rv & (1 << 8), 32'h0);
    restore();

    // R8 / R9 group boundaries
    for (int k = 0; k < 7; k++) begin
      int ln;
      case (k)
        0: ln = 3;  1: ln = 4;  2: ln = 11; 3: ln = 12;
        4: ln = 19; 5: ln = 20; default: ln = 27;
      endcase
      wr(2'd2, 32'hFFFF_FFFF);
      wr(2'd3, 32'hFFFF_FFFF);
      pulse_high(ln);
      check("R8 masked line keeps grp low", {28'h0, grp_irq}, 32'h0);
      rd(2'd3, rv); check("R8 masked flag visible", rv, 32'h1 << ln);
      wr(2'd2, 32'h0);
      check("R9 group of line", {28'h0, grp_irq}, {28'h0, grp_of(ln)});
    end
    wr(2'd2, 32'hFFFF_FFFF);
    wr(2'd3, 32'hFFFF_FFFF);

    // R4 / R5 random trials over codes and levels
    for (int t = 0; t < 48; t++) begin
      int n;
      logic [2:0] m;
      bit v0, v1;
      logic [31:0] cv;
      n  = int'($urandom % 28);
      m  = 3'($urandom);
      v0 = 1'($urandom);
      v1 = 1'($urandom);
      cv = (n < 16) ? RST_LO : RST_HI;
      cv = (cv & ~(32'h7 << lsb_of(n))) | (32'(m) << lsb_of(n));
      line_in[n] = v0;
      step(4);
      wr((n < 16) ? 2'd0 : 2'd1, cv);
      step(1);
      wr(2'd3, 32'h1 << n);
      step(1);
      line_in[n] = v1;
      step(3);
      rd(2'd3, rv);
      check((m[2:1] == 2'b00) ? "R4 random level trial" : "R5 random edge trial",
            (rv >> n) & 32'h1, {31'h0, exp_flag(m, v0, v1)});
      restore();
    end

    summary();
  end
endmodule